// File: doc/BRIEF.md
# Dual-Bank Clock Divider With Feedback Output

This block turns one fast source clock into three slower ones. Bank A runs at a chosen multiple of the reference rate. Bank B runs either at the bank A rate or at half of it. The third output is a feedback clock that always runs at the reference rate, so an outer phase loop can lock the source to the reference.

A 4-bit select code sets all three divide ratios at once. The code is taken in only while the block is held in reset. A bypass input replaces the oscillator with the reference clock as the source clock, which gives a static test path.

An output-enable input parks both banks low and reports them as not driven. The feedback divider keeps running during this time. When the enable returns, the banks restart on a feedback rising edge, so all three outputs stay phase aligned.

Top module: `clk_bank_divider`

## Requirements
- R1: While `rst_ni` is low, `fb_o`, `bank_a_o`, `bank_b_o` and `bank_drv_en_o` are all 0. The clear is asynchronous.
- R2: After `rst_ni` rises, `fb_o` first goes high on the third rising source edge. If `oe_i` is high at that edge, `bank_a_o`, `bank_b_o` and `bank_drv_en_o` also go high on that same edge.
- R3: The feedback divide N is set by `fsel_i[3:1]` as follows:
  - codes 4 and 7: N = 4
  - code 2: N = 6
  - codes 1, 3 and 6: N = 8
  - codes 0 and 5: N = 16

  `fb_o` is high for the first N/2 source cycles of each N-cycle period.
- R4: The bank A divide is set by `fsel_i[3:1]` as follows:
  - codes 0, 1, 2 and 4: 2
  - codes 3 and 7: 4
  - code 6: 8
  - code 5: 16

  Bank A has 50% duty, and its period starts where the bank start edge is.
- R5: With `fsel_i[0]` = 0, bank B has the bank A divide. With `fsel_i[0]` = 1, bank B has twice the bank A divide. The duty is 50%.
- R6: Every rising edge of `bank_b_o` falls on a rising edge of `bank_a_o`.
- R7: A source edge that samples `oe_i` low forces `bank_a_o`, `bank_b_o` and `bank_drv_en_o` to 0. They stay at 0 while `oe_i` stays low. `fb_o` keeps its pattern.
- R8: With `oe_i` high and the banks stopped, the banks restart on the first source edge where `fb_o` rises. `bank_drv_en_o` goes high on that same edge.
- R9: A change of `fsel_i` while the block runs has no effect until `rst_ni` is next asserted.
- R10: With `bypass_i` = 1, `ref_clk_i` is the source clock in place of `osc_clk_i`, with the same divide ratios. `bypass_i` is changed only while in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk_i | input | 1 | Fast oscillator clock |
| ref_clk_i | input | 1 | Reference clock, used as source in bypass |
| bypass_i | input | 1 | 1 selects the reference clock as source |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| oe_i | input | 1 | Bank output enable; low stops and resets the banks |
| fsel_i | input | 4 | Ratio code: [3:1] mode, [0] bank B half rate |
| bank_a_o | output | 1 | Bank A clock |
| bank_b_o | output | 1 | Bank B clock |
| fb_o | output | 1 | Feedback clock at reference rate |
| bank_drv_en_o | output | 1 | High while the bank outputs are driven |

## Verification
All clock outputs are registered on the source clock.

- **Reset release:** the first rising edge arrives on the third source edge after reset is released.
- **Enable and disable:** a change of the enable shows up on the next source edge. A restart then waits for the next feedback rising edge.

The bench keeps a model of edge and phase counters that advances on each rising source edge. It drives inputs only after a falling edge and compares every output at the following falling edge. Each compare therefore sees exactly one new edge of the register outputs. The reset check is taken one time step after the asynchronous assertion.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W = 6;
  typedef logic [DIV_W-1:0] div_t;

  typedef enum logic [2:0] {
    MODE_X8     = 3'd0,
    MODE_X4     = 3'd1,
    MODE_X3     = 3'd2,
    MODE_X2_MID = 3'd3,
    MODE_X2_HI  = 3'd4,
    MODE_X1_LO  = 3'd5,
    MODE_X1_MID = 3'd6,
    MODE_X1_HI  = 3'd7
  } mode_e;

  function automatic div_t fb_divide(mode_e m);
    case (m)
      MODE_X2_HI, MODE_X1_HI:               fb_divide = div_t'(4);
      MODE_X3:                              fb_divide = div_t'(6);
      MODE_X4, MODE_X2_MID, MODE_X1_MID:    fb_divide = div_t'(8);
      default:                              fb_divide = div_t'(16);
    endcase
  endfunction

  function automatic div_t bank_a_divide(mode_e m);
    case (m)
      MODE_X2_MID, MODE_X1_HI: bank_a_divide = div_t'(4);
      MODE_X1_MID:             bank_a_divide = div_t'(8);
      MODE_X1_LO:              bank_a_divide = div_t'(16);
      default:                 bank_a_divide = div_t'(2);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign run_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  div_t div_i,
  output logic wrap_o,
  output logic clk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt, last;
  logic             out_q, out_d;

  always_comb begin
    last   = CNT_W'(div_i - div_t'(1));
    nxt    = (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
    wrap_o = (nxt == '0);
    cnt_d  = run_i ? nxt : '1;
    out_d  = run_i && (DIV_W'(nxt) < (div_i >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;

  AST_RISE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> (cnt_q == '0)); // R3
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5,
  parameter int SEL_W       = 4
) (
  input  logic             osc_clk_i,
  input  logic             ref_clk_i,
  input  logic             bypass_i,
  input  logic             rst_ni,
  input  logic             oe_i,
  input  logic [SEL_W-1:0] fsel_i,
  output logic             bank_a_o,
  output logic             bank_b_o,
  output logic             fb_o,
  output logic             bank_drv_en_o
);
  localparam int NUM_BANKS = 2;

  logic src_clk;
  assign src_clk = bypass_i ? ref_clk_i : osc_clk_i;

  logic run;
  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (src_clk),
    .rst_ni(rst_ni),
    .run_o (run)
  );

  // select code: captured only while held in reset
  logic [SEL_W-1:0] sel_q, sel_d;
  always_comb sel_d = run ? sel_q : fsel_i;
  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  mode_e mode;
  div_t  fb_div, a_div;
  div_t  bank_div [NUM_BANKS];
  assign mode        = mode_e'(sel_q[SEL_W-1:1]);
  assign fb_div      = fb_divide(mode);
  assign a_div       = bank_a_divide(mode);
  assign bank_div[0] = a_div;
  assign bank_div[1] = sel_q[0] ? div_t'(a_div << 1) : a_div;

  logic fb_wrap_raw, fb_wrap;
  clkdiv_counter #(.CNT_W(CNT_W)) u_fb (
    .clk_i (src_clk),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (fb_div),
    .wrap_o(fb_wrap_raw),
    .clk_o (fb_o)
  );
  assign fb_wrap = run && fb_wrap_raw;

  // banks start or restart only on a feedback wrap edge
  logic bank_run_q, bank_run_d;
  always_comb bank_run_d = run && oe_i && (bank_run_q || fb_wrap);
  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) bank_run_q <= 1'b0;
    else         bank_run_q <= bank_run_d;
  end

  logic [NUM_BANKS-1:0] bank_clk, bank_wrap;
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    clkdiv_counter #(.CNT_W(CNT_W)) u_div (
      .clk_i (src_clk),
      .rst_ni(rst_ni),
      .run_i (bank_run_d),
      .div_i (bank_div[g]),
      .wrap_o(bank_wrap[g]),
      .clk_o (bank_clk[g])
    );
  end

  assign bank_a_o      = bank_clk[0];
  assign bank_b_o      = bank_clk[1];
  assign bank_drv_en_o = bank_run_q;

  AST_BANKS_OFF_WHEN_DISABLED: assert property (@(posedge src_clk) disable iff (!rst_ni)
    !oe_i |=> (!bank_a_o && !bank_b_o && !bank_drv_en_o)); // R7
  AST_B_RISE_ON_A_RISE: assert property (@(posedge src_clk) disable iff (!rst_ni)
    $rose(bank_b_o) |-> $rose(bank_a_o)); // R6
  AST_B_WRAP_ON_A_WRAP: assert property (@(posedge src_clk) disable iff (!rst_ni)
    (bank_run_q && bank_wrap[1]) |-> bank_wrap[0]); // R6
  AST_BANK_START_ON_FB: assert property (@(posedge src_clk) disable iff (!rst_ni)
    $rose(bank_drv_en_o) |-> $rose(fb_o)); // R8
  AST_SEL_HELD: assert property (@(posedge src_clk) disable iff (!rst_ni)
    (run && $past(run)) |-> $stable(sel_q)); // R9
endmodule

// File: tb/sim_clk_bank_divider.sv
module sim_clk_bank_divider;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 26;

  logic osc_clk = 1'b0;
  logic ref_clk = 1'b0;
  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  logic       bypass, rst_n, oe;
  logic [3:0] fsel;
  logic       qa, qb, qfb, den;

  clk_bank_divider u0 (
    .osc_clk_i    (osc_clk),
    .ref_clk_i    (ref_clk),
    .bypass_i     (bypass),
    .rst_ni       (rst_n),
    .oe_i         (oe),
    .fsel_i       (fsel),
    .bank_a_o     (qa),
    .bank_b_o     (qb),
    .fb_o         (qfb),
    .bank_drv_en_o(den)
  );

  logic b_src;
  assign b_src = bypass ? ref_clk : osc_clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  int  e, fbk, bk, fbN, aN, bN;
  bit  fbrun, brun, sel_moved;

  function automatic int exp_fb_div(int m);
    case (m)
      4, 7:    return 4;
      2:       return 6;
      1, 3, 6: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_a_div(int m);
    case (m)
      3, 7:    return 4;
      6:       return 8;
      5:       return 16;
      default: return 2;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t edge=%0d actual=%b expected=%b", tag, $time, e, act, exp);
    end
  endtask

  task automatic start_run(input int code, input bit byp);
    @(negedge b_src);
    rst_n = 1'b0;
    #1;
    chk("R1", qfb, 1'b0);
    chk("R1", qa, 1'b0);
    chk("R1", qb, 1'b0);
    chk("R1", den, 1'b0);
    fsel   = code[3:0];
    bypass = byp;
    repeat (3) @(negedge b_src);
    chk("R1", qfb, 1'b0);
    chk("R1", den, 1'b0);
    rst_n     = 1'b1;
    e         = 0;
    fbrun     = 0;
    brun      = 0;
    fbk       = 0;
    bk        = 0;
    sel_moved = 0;
    fbN       = exp_fb_div(code >> 1);
    aN        = exp_a_div(code >> 1);
    bN        = code[0] ? 2 * aN : aN;
  endtask

  task automatic step();
    bit  ea, eb, ef;
    @(posedge b_src);
    e++;
    if (e == 3) begin
      fbrun = 1;
      fbk   = 0;
    end else if (fbrun) begin
      fbk++;
    end
    if (!oe) begin
      brun = 0;
    end else if (brun) begin
      bk++;
    end else if (fbrun && (fbk % fbN) == 0) begin
      brun = 1;
      bk   = 0;
    end
    @(negedge b_src);
    ef = fbrun && ((fbk % fbN) < fbN / 2);
    ea = brun && ((bk % aN) < aN / 2);
    eb = brun && ((bk % bN) < bN / 2);
    chk(e <= 3 ? "R2" : (sel_moved ? "R9" : (bypass ? "R10" : "R3")), qfb, ef);
    chk(!oe ? "R7" : "R4", qa, ea);
    chk((brun && (bk % bN) == 0) ? "R6" : "R5", qb, eb);
    chk(!oe ? "R7" : "R8", den, brun);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n  = 1'b0;
    oe     = 1'b1;
    fsel   = 4'd0;
    bypass = 1'b0;
    #(CLK_PERIOD * 3);

    // every code with oscillator source (R3, R4, R5)
    for (int c = 0; c < 16; c++) begin
      start_run(c, 1'b0);
      repeat (70) step();
    end

    // disable and re-enable on a mode with unequal periods (R7, R8)
    start_run(5, 1'b0);
    repeat (19) step();
    oe = 1'b0;
    repeat (9) step();
    oe = 1'b1;
    repeat (40) step();

    // enable held low through release (R2, R8)
    oe = 1'b0;
    start_run(13, 1'b0);
    repeat (20) step();
    oe = 1'b1;
    repeat (60) step();

    // select change while running is ignored (R9)
    start_run(0, 1'b0);
    repeat (10) step();
    fsel      = 4'hF;
    sel_moved = 1;
    repeat (60) step();

    // bypass source (R10)
    start_run(14, 1'b1);
    repeat (40) step();
    start_run(3, 1'b1);
    repeat (40) step();

    // random mix
    for (int r = 0; r < 12; r++) begin
      oe = 1'b1;
      start_run(int'($urandom % 16), 1'($urandom % 2));
      for (int s = 0; s < 150; s++) begin
        if (s == 30) begin
          fsel      = 4'($urandom);
          sel_moved = 1;
        end
        if (($urandom % 12) == 0) oe = ~oe;
        step();
      end
    end

    bypass = 1'b0;
    start_run(0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule